// File: doc/BRIEF.md
# Byte and Word Bus Alignment Network

This block sits between a 16-bit processor data path and a 16-bit memory data path. It lets the processor move either a full 16-bit word or a single byte. The access type comes from three inputs: a write flag, a byte-size flag and the lowest address bit. From these, a small decoder sets the steering of each 8-bit lane in both directions, a two-bit write byte-enable to memory, and a fault flag.

For byte reads, the selected memory byte always arrives in the low processor lane and the high processor lane reads as zero. For byte writes, the processor's low byte is copied onto both memory lanes, and the byte-enable picks the half that is stored. Memory sees a word address, which is the processor address without its lowest bit. A word access at an odd address is not split into two cycles. Instead it raises the fault flag, returns zero read data and drives no write enables, so memory cannot change.

The network is purely combinational. Every output follows its inputs within the same cycle.

Top module: `align_net`

## Requirements
- R1: `mem_addr` always equals `cpu_addr[15:1]`.
- R2: `fault` is 1 exactly when `byte_mode`=0 and `cpu_addr[0]`=1. This holds for reads and writes alike.
- R3: A word access (`byte_mode`=0, `cpu_addr[0]`=0) returns `cpu_rdata` = `mem_rdata`, whatever the value of `wr`.
- R4: An even byte access (`byte_mode`=1, `cpu_addr[0]`=0) returns `cpu_rdata` = {8'h00, `mem_rdata[7:0]`}.
- R5: An odd byte access (`byte_mode`=1, `cpu_addr[0]`=1) returns `cpu_rdata` = {8'h00, `mem_rdata[15:8]`}.
- R6: A word access drives `mem_wdata` = `cpu_wdata`. When `wr`=1 it also drives `mem_be` = 2'b11. Bit 0 of `mem_be` enables the low memory byte and bit 1 enables the high memory byte.
- R7: A byte access drives `mem_wdata` = {`cpu_wdata[7:0]`, `cpu_wdata[7:0]`}. When `wr`=1, `mem_be` is 2'b01 for an even address and 2'b10 for an odd address.
- R8: While `fault` is 1, `cpu_rdata`, `mem_wdata` and `mem_be` are all zero.
- R9: When `wr`=0, `mem_be` is 2'b00 for every access type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_addr | input | 16 | Processor byte address |
| wr | input | 1 | 1 = write access, 0 = read access |
| byte_mode | input | 1 | 1 = single byte access, 0 = word access |
| cpu_wdata | input | 16 | Write data from the processor |
| mem_rdata | input | 16 | Read data from memory |
| cpu_rdata | output | 16 | Aligned read data to the processor |
| mem_wdata | output | 16 | Lane-steered write data to memory |
| mem_addr | output | 15 | Word address to memory |
| mem_be | output | 2 | Write byte enables, bit 0 low lane, bit 1 high lane |
| fault | output | 1 | Misaligned word access indication |

## Verification
The checker assumes its inputs are settled, two-valued levels whenever it evaluates. This is safe because the network has no state, so each output is a pure function of the current inputs. The bench meets this by changing the inputs only just after a rising clock edge and reading the outputs at the falling edge. Data values are drawn at random. The control combinations are set by hand so that each of the four access kinds is reached with both values of `wr`. This lets the don't-care write flag be shown to have no effect on routing.

// File: rtl/align_pkg.sv
package align_pkg;

    localparam int CPU_ADDR_W = 16;
    localparam int LANE_W     = 8;
    localparam int NUM_LANES  = 2;
    localparam int DATA_W     = LANE_W * NUM_LANES;
    localparam int MEM_ADDR_W = CPU_ADDR_W - 1;

    // Kind of access implied by size flag and lowest address bit
    typedef enum logic [1:0] {
        ACC_WORD,
        ACC_LOW_BYTE,
        ACC_HIGH_BYTE,
        ACC_MISALIGNED
    } acc_kind_e;

    // Source chosen for one destination lane
    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_LOW,
        SRC_HIGH
    } lane_src_e;

    typedef struct packed {
        lane_src_e [NUM_LANES-1:0] rd_src;
        lane_src_e [NUM_LANES-1:0] wr_src;
        logic      [NUM_LANES-1:0] lane_en;
        logic                      fault;
    } steer_t;

    function automatic acc_kind_e classify(input logic byte_mode, input logic lsb);
        acc_kind_e k;
        case ({byte_mode, lsb})
            2'b00:   k = ACC_WORD;
            2'b01:   k = ACC_MISALIGNED;
            2'b10:   k = ACC_LOW_BYTE;
            default: k = ACC_HIGH_BYTE;
        endcase
        return k;
    endfunction

    function automatic steer_t steer_for(input acc_kind_e kind);
        steer_t s;
        s.fault   = 1'b0;
        s.lane_en = '0;
        s.rd_src  = {SRC_ZERO, SRC_ZERO};
        s.wr_src  = {SRC_ZERO, SRC_ZERO};
        case (kind)
            ACC_WORD: begin
                s.rd_src  = {SRC_HIGH, SRC_LOW};
                s.wr_src  = {SRC_HIGH, SRC_LOW};
                s.lane_en = 2'b11;
            end
            ACC_LOW_BYTE: begin
                s.rd_src  = {SRC_ZERO, SRC_LOW};
                s.wr_src  = {SRC_LOW, SRC_LOW};
                s.lane_en = 2'b01;
            end
            ACC_HIGH_BYTE: begin
                s.rd_src  = {SRC_ZERO, SRC_HIGH};
                s.wr_src  = {SRC_LOW, SRC_LOW};
                s.lane_en = 2'b10;
            end
            default: begin
                s.fault = 1'b1;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/align_decode.sv
module align_decode
    import align_pkg::*;
(
    input  logic   wr,
    input  logic   byte_mode,
    input  logic   addr_lsb,
    output steer_t steer
);

    acc_kind_e kind;
    steer_t    raw;

    always_comb begin
        kind  = classify(byte_mode, addr_lsb);
        raw   = steer_for(kind);
        steer = raw;
        // byte enables only qualify stores
        steer.lane_en = wr ? raw.lane_en : '0;
    end

endmodule

// File: rtl/align_lane_mux.sv
module align_lane_mux
    import align_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  lane_src_e      sel,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   hi,
    output logic [W-1:0]   y
);

    always_comb begin
        case (sel)
            SRC_LOW:  y = lo;
            SRC_HIGH: y = hi;
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/align_net.sv
module align_net
    import align_pkg::*;
(
    input  logic [CPU_ADDR_W-1:0] cpu_addr,
    input  logic                  wr,
    input  logic                  byte_mode,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [MEM_ADDR_W-1:0] mem_addr,
    output logic [NUM_LANES-1:0]  mem_be,
    output logic                  fault
);

    steer_t steer;

    align_decode u_dec (
        .wr        (wr),
        .byte_mode (byte_mode),
        .addr_lsb  (cpu_addr[0]),
        .steer     (steer)
    );

    assign mem_addr = cpu_addr[CPU_ADDR_W-1:1];
    assign mem_be   = steer.lane_en;
    assign fault    = steer.fault;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        align_lane_mux #(.W(LANE_W)) u_rd_mux (
            .sel (steer.rd_src[g]),
            .lo  (mem_rdata[LANE_W-1:0]),
            .hi  (mem_rdata[DATA_W-1:LANE_W]),
            .y   (cpu_rdata[g*LANE_W +: LANE_W])
        );
        align_lane_mux #(.W(LANE_W)) u_wr_mux (
            .sel (steer.wr_src[g]),
            .lo  (cpu_wdata[LANE_W-1:0]),
            .hi  (cpu_wdata[DATA_W-1:LANE_W]),
            .y   (mem_wdata[g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/align_chk.sv
module align_chk
    import align_pkg::*;
(
    input logic [CPU_ADDR_W-1:0] cpu_addr,
    input logic                  wr,
    input logic                  byte_mode,
    input logic [DATA_W-1:0]     cpu_wdata,
    input logic [DATA_W-1:0]     mem_rdata,
    input logic [DATA_W-1:0]     cpu_rdata,
    input logic [DATA_W-1:0]     mem_wdata,
    input logic [MEM_ADDR_W-1:0] mem_addr,
    input logic [NUM_LANES-1:0]  mem_be,
    input logic                  fault
);

    logic word_ok;
    assign word_ok = !byte_mode && !cpu_addr[0];

    always_comb begin
        // R1
        addr_map_chk: assert (mem_addr == cpu_addr[CPU_ADDR_W-1:1])
            else $error("mem_addr mismatch");
        // R2
        fault_cause_chk: assert (fault == (!byte_mode && cpu_addr[0]))
            else $error("fault cause mismatch");
        // R3
        word_read_chk: assert (!word_ok || cpu_rdata == mem_rdata)
            else $error("word read routing");
        // R4 R5
        byte_upper_zero_chk: assert (!byte_mode || cpu_rdata[DATA_W-1:LANE_W] == '0)
            else $error("byte read upper lane not zero");
        // R6
        word_write_chk: assert (!word_ok || mem_wdata == cpu_wdata)
            else $error("word write routing");
        // R7
        byte_dup_chk: assert (!byte_mode || mem_wdata[DATA_W-1:LANE_W] == mem_wdata[LANE_W-1:0])
            else $error("byte write lanes differ");
        // R7
        byte_be_chk: assert (!(byte_mode && wr) || $countones(mem_be) == 1)
            else $error("byte write enables");
        // R8
        fault_quiet_chk: assert (!fault || (mem_be == '0 && cpu_rdata == '0 && mem_wdata == '0))
            else $error("fault not quiet");
        // R9
        read_be_chk: assert (wr || mem_be == '0)
            else $error("enables during read");
    end

endmodule

bind align_net align_chk u_align_chk (
    .cpu_addr  (cpu_addr),
    .wr        (wr),
    .byte_mode (byte_mode),
    .cpu_wdata (cpu_wdata),
    .mem_rdata (mem_rdata),
    .cpu_rdata (cpu_rdata),
    .mem_wdata (mem_wdata),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .fault     (fault)
);

// File: tb/test_align_net.sv
module test_align_net;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        wr = 1'b0;
    logic        byte_mode = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] cpu_rdata;
    logic [15:0] mem_wdata;
    logic [14:0] mem_addr;
    logic [1:0]  mem_be;
    logic        fault;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    align_net i_align_net (
        .cpu_addr  (cpu_addr),
        .wr        (wr),
        .byte_mode (byte_mode),
        .cpu_wdata (cpu_wdata),
        .mem_rdata (mem_rdata),
        .cpu_rdata (cpu_rdata),
        .mem_wdata (mem_wdata),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .fault     (fault)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic w, input logic b,
                         input logic [15:0] wd, input logic [15:0] rd);
        @(posedge clk);
        #0.5;
        cpu_addr  = a;
        wr        = w;
        byte_mode = b;
        cpu_wdata = wd;
        mem_rdata = rd;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R3", "reset rdata", cpu_rdata, 16'h0000);
        chk("R9", "reset be", {14'b0, mem_be}, 16'h0000);
        chk("R2", "reset fault", {15'b0, fault}, 16'h0000);
    endtask

    task automatic t_addr_map();
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            apply(a, i[0], i[1], 16'h0, 16'h0);
            chk("R1", "mem_addr", {1'b0, mem_addr}, {1'b0, a[15:1]});
        end
        apply(16'hFFFF, 1'b0, 1'b1, 16'h0, 16'h0);
        chk("R1", "mem_addr max", {1'b0, mem_addr}, 16'h7FFF);
    endtask

    task automatic t_word_access();
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a, wd, rd;
            a  = 16'($urandom) & 16'hFFFE;
            wd = 16'($urandom);
            rd = 16'($urandom);
            apply(a, i[0], 1'b0, wd, rd);
            chk("R3", "word rdata", cpu_rdata, rd);
            chk("R6", "word wdata", mem_wdata, wd);
            chk("R6", "word be", {14'b0, mem_be}, i[0] ? 16'h0003 : 16'h0000);
            chk("R2", "word fault", {15'b0, fault}, 16'h0000);
        end
    endtask

    task automatic t_even_byte();
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a, wd, rd;
            a  = 16'($urandom) & 16'hFFFE;
            wd = 16'($urandom);
            rd = 16'($urandom);
            apply(a, i[0], 1'b1, wd, rd);
            chk("R4", "even rdata", cpu_rdata, {8'h00, rd[7:0]});
            chk("R7", "even wdata", mem_wdata, {wd[7:0], wd[7:0]});
            chk("R7", "even be", {14'b0, mem_be}, i[0] ? 16'h0001 : 16'h0000);
        end
    endtask

    task automatic t_odd_byte();
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a, wd, rd;
            a  = 16'($urandom) | 16'h0001;
            wd = 16'($urandom);
            rd = 16'($urandom);
            apply(a, i[0], 1'b1, wd, rd);
            chk("R5", "odd rdata", cpu_rdata, {8'h00, rd[15:8]});
            chk("R7", "odd wdata", mem_wdata, {wd[7:0], wd[7:0]});
            chk("R7", "odd be", {14'b0, mem_be}, i[0] ? 16'h0002 : 16'h0000);
            chk("R2", "odd byte fault", {15'b0, fault}, 16'h0000);
        end
    endtask

    task automatic t_misaligned();
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a;
            a = 16'($urandom) | 16'h0001;
            apply(a, i[0], 1'b0, 16'hFFFF, 16'hFFFF);
            chk("R2", "misaligned fault", {15'b0, fault}, 16'h0001);
            chk("R8", "fault rdata", cpu_rdata, 16'h0000);
            chk("R8", "fault wdata", mem_wdata, 16'h0000);
            chk("R8", "fault be", {14'b0, mem_be}, 16'h0000);
        end
    endtask

    task automatic t_read_no_enable();
        apply(16'h1234, 1'b0, 1'b0, 16'hA5A5, 16'h5A5A);
        chk("R9", "word read be", {14'b0, mem_be}, 16'h0000);
        apply(16'h1234, 1'b0, 1'b1, 16'hA5A5, 16'h5A5A);
        chk("R9", "even read be", {14'b0, mem_be}, 16'h0000);
        apply(16'h1235, 1'b0, 1'b1, 16'hA5A5, 16'h5A5A);
        chk("R9", "odd read be", {14'b0, mem_be}, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_addr_map();
        t_word_access();
        t_even_byte();
        t_odd_byte();
        t_misaligned();
        t_read_no_enable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule